// File: doc/BRIEF.md
# Receive Error Status and Transfer Gate

This block sits between the receive shift register of a serial controller and its receive FIFO. Each time a character finishes arriving, the shift register gives one pulse of `in_valid` with the byte and two error indications: a missing stop bit (framing) and a parity mismatch. The gate decides whether the byte goes on toward the FIFO, and it updates four sticky status flags: receive-data-full, overrun, framing error and parity error. One character can raise several of these flags at once.

Toward the FIFO the block has a single-entry valid/ready output stage. `ff_valid` rises one cycle after a byte is accepted. Once `ff_valid` is high, it and the tagged byte stay fixed until the FIFO takes them with `ff_ready`. The shift register cannot be stalled, so the input side has no ready. FIFO back-pressure shows up instead as overrun: if a character completes while the output stage is still occupied and not being drained in that cycle, the byte is dropped. A framing or parity error alone does not block the transfer. The byte goes through with its error tags attached.

Software clears a flag in two steps. First it reads the status (`sts_rd`) while the flag is 1. Then it writes 0 to that flag's bit (`sts_wr`). A new error event always wins over a clear that lands in the same cycle.

Top module: `rxg_gate`

## Requirements
- R1: A character with no errors that arrives while the output stage is free appears on `ff_data` with `ff_valid` high on the next cycle, with both error tags low, and no status flag changes.
- R2: A character with only a framing error is still transferred, with `ff_fer` high. It sets flag bit 1 (framing) and leaves bits 2 (overrun) and 3 (receive-data-full) unchanged.
- R3: A character with only a parity error is still transferred, with `ff_per` high. It sets flag bit 0 (parity) and leaves bits 2 and 3 unchanged.
- R4: A character with both framing and parity errors and no overrun is transferred with both tags high and sets bits 0 and 1.
- R5: Overrun happens when a character completes while `ff_valid` is high and `ff_ready` is low. The new byte is dropped and the held byte stays unchanged. Bits 2 and 3 are both set, and bits 1 and 0 are also set if the dropped character carried a framing or parity error.
- R6: While `ff_valid` is high and `ff_ready` is low, `ff_valid` stays high and `ff_data`, `ff_fer` and `ff_per` stay unchanged. A character that completes in the same cycle the held byte is taken is accepted, not counted as overrun.
- R7: A flag clears only when a `sts_rd` saw it as 1 and the next `sts_wr` writes 0 to its bit. Writing 0 without such a read, or writing 1, leaves the flag unchanged. Any write ends the read's effect.
- R8: An event that sets a flag in the same cycle as a write that would clear it leaves the flag at 1.
- R9: After reset `ff_valid` is 0 and all four status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One-cycle pulse: a character has completed |
| in_data | input | DATA_W | Completed character |
| in_fer | input | 1 | Framing error on this character |
| in_per | input | 1 | Parity error on this character |
| ff_valid | output | 1 | Output stage holds a byte for the FIFO |
| ff_ready | input | 1 | FIFO accepts the held byte |
| ff_data | output | DATA_W | Held byte |
| ff_fer | output | 1 | Framing error tag of the held byte |
| ff_per | output | 1 | Parity error tag of the held byte |
| sts_rd | input | 1 | Status read strobe; arms each flag that reads 1 |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 4 | Write data; 0 in an armed bit clears that flag |
| sts_flags | output | 4 | Flags: bit 3 receive-data-full, 2 overrun, 1 framing, 0 parity |

## Verification
Two situations are the hardest to reach from the ports. The first is a character that lands in the exact cycle the held byte drains, which must be accepted rather than dropped. The second is a clearing write that coincides with a fresh error on the same flag. Directed steps set up both on purpose: they hold `ff_ready` low to fill the stage, arm the flags with a read, and then raise `ff_ready`, `sts_wr` and an erroneous character together. A long seeded random run then mixes back-pressure, errors, reads and writes. Every cycle is compared with a reference model written from the requirements.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int FLAG_N   = 4;
  localparam int IDX_PER  = 0;
  localparam int IDX_FER  = 1;
  localparam int IDX_ORER = 2;
  localparam int IDX_RDF  = 3;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/rxg_classify.sv
module rxg_classify
  import rxg_pkg::*;
(
  input  logic      chr_valid,
  input  logic      chr_fer,
  input  logic      chr_per,
  input  logic      stage_full,
  input  logic      stage_drain,
  output logic      accept,
  output logic      overrun,
  output flag_vec_t set_vec
);
  // Overrun: the stage stays occupied across this edge.
  always_comb begin
    overrun = chr_valid & stage_full & ~stage_drain;
    accept  = chr_valid & ~overrun;
    set_vec = '0;
    set_vec[IDX_PER]  = chr_valid & chr_per;
    set_vec[IDX_FER]  = chr_valid & chr_fer;
    set_vec[IDX_ORER] = overrun;
    set_vec[IDX_RDF]  = overrun;
  end
endmodule

// File: rtl/rxg_slot.sv
module rxg_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_fer,
  input  logic              load_per,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fer,
  output logic              out_per
);
  localparam int TAG_W = 2;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      tag_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      tag_q     <= {load_fer, load_per};
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_fer = tag_q[1];
  assign out_per = tag_q[0];

  // Back-pressure holds the offered byte
  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(tag_q)));
endmodule

// File: rtl/rxg_flag.sv
module rxg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd,
  input  logic wr,
  input  logic wbit,
  output logic flag
);
  logic armed;
  logic clr;

  assign clr = wr & armed & ~wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag <= set_ev | (flag & ~clr);
      if (rd)      armed <= flag;
      else if (wr) armed <= 1'b0;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  assert_no_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr) |=> flag);
  assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr && wbit) |=> flag);
  assert_unarmed_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);
endmodule

// File: rtl/rxg_gate.sv
module rxg_gate
  import rxg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_fer,
  input  logic              in_per,
  output logic              ff_valid,
  input  logic              ff_ready,
  output logic [DATA_W-1:0] ff_data,
  output logic              ff_fer,
  output logic              ff_per,
  input  logic              sts_rd,
  input  logic              sts_wr,
  input  logic [FLAG_N-1:0] sts_wdata,
  output logic [FLAG_N-1:0] sts_flags
);
  logic      accept;
  logic      overrun;
  flag_vec_t set_vec;
  logic      drain;

  assign drain = ff_valid & ff_ready;

  rxg_classify u_cls (
    .chr_valid  (in_valid),
    .chr_fer    (in_fer),
    .chr_per    (in_per),
    .stage_full (ff_valid),
    .stage_drain(drain),
    .accept     (accept),
    .overrun    (overrun),
    .set_vec    (set_vec)
  );

  rxg_slot #(.DATA_W(DATA_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_data(in_data),
    .load_fer (in_fer),
    .load_per (in_per),
    .out_ready(ff_ready),
    .out_valid(ff_valid),
    .out_data (ff_data),
    .out_fer  (ff_fer),
    .out_per  (ff_per)
  );

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    rxg_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_ev(set_vec[i]),
      .rd    (sts_rd),
      .wr    (sts_wr),
      .wbit  (sts_wdata[i]),
      .flag  (sts_flags[i])
    );
  end

  // Overrun drops the new byte; the held one stays put
  assert_overrun_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ff_valid && !ff_ready) |=> (ff_valid && $stable(ff_data)));
  assert_overrun_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_flags[IDX_ORER]) |-> sts_flags[IDX_RDF]);
  assert_clean_transfer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_fer && !in_per && (!ff_valid || ff_ready))
      |=> (ff_valid && ff_data == $past(in_data) && !ff_fer && !ff_per));
  assert_error_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_fer || in_per) && (!ff_valid || ff_ready))
      |=> (ff_valid && ff_fer == $past(in_fer) && ff_per == $past(in_per)));
  assert_drain_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ff_valid && ff_ready) |=> (ff_valid && ff_data == $past(in_data)));
endmodule

// File: tb/rxg_gate_test.sv
module rxg_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_fer = 1'b0, in_per = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         ff_ready = 1'b0;
  logic         sts_rd = 1'b0, sts_wr = 1'b0;
  logic [3:0]   sts_wdata = '0;
  logic         ff_valid, ff_fer, ff_per;
  logic [W-1:0] ff_data;
  logic [3:0]   sts_flags;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  bit         m_valid = 0, m_fer = 0, m_per = 0;
  bit [W-1:0] m_data = '0;
  bit [3:0]   m_flags = '0, m_armed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxg_gate #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_fer(in_fer), .in_per(in_per),
    .ff_valid(ff_valid), .ff_ready(ff_ready), .ff_data(ff_data),
    .ff_fer(ff_fer), .ff_per(ff_per),
    .sts_rd(sts_rd), .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_flags(sts_flags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected status after one character and control cycle
  function automatic bit [3:0] next_flags(bit [3:0] f, bit [3:0] armed, bit ovr,
                                          bit iv, bit fe, bit pe, bit wr, bit [3:0] wd);
    bit [3:0] setv, clr;
    setv = {ovr, ovr, iv & fe, iv & pe};
    clr  = wr ? (armed & ~wd) : 4'b0;
    return setv | (f & ~clr);
  endfunction

  // apply one cycle at a negedge, advance model, return at next negedge
  task automatic step(input bit iv, input bit [W-1:0] d, input bit fe, input bit pe,
                      input bit rdy, input bit rd, input bit wr, input bit [3:0] wd);
    bit ovr, acc;
    in_valid = iv; in_data = d; in_fer = fe; in_per = pe;
    ff_ready = rdy; sts_rd = rd; sts_wr = wr; sts_wdata = wd;
    ovr = iv && m_valid && !rdy;
    acc = iv && !ovr;
    m_flags = next_flags(m_flags, m_armed, ovr, iv, fe, pe, wr, wd);
    if (rd)      m_armed = m_flags_prev_hold(rd);
    else if (wr) m_armed = '0;
    if (acc) begin
      m_valid = 1; m_data = d; m_fer = fe; m_per = pe;
    end else if (m_valid && rdy) begin
      m_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // armed copy of the pre-edge flags, captured before the model update
  bit [3:0] pre_flags = '0;
  function automatic bit [3:0] m_flags_prev_hold(bit rd);
    return rd ? pre_flags : 4'b0;
  endfunction

  task automatic stepc(input bit iv, input bit [W-1:0] d, input bit fe, input bit pe,
                       input bit rdy, input bit rd, input bit wr, input bit [3:0] wd);
    pre_flags = m_flags;
    step(iv, d, fe, pe, rdy, rd, wr, wd);
  endtask

  task automatic compare(input string req);
    chk(ff_valid == m_valid, {req, " ff_valid"}, ff_valid, m_valid);
    if (m_valid) begin
      chk(ff_data == m_data, {req, " ff_data"}, ff_data, m_data);
      chk({ff_fer, ff_per} == {m_fer, m_per}, {req, " tags"}, {ff_fer, ff_per}, {m_fer, m_per});
    end
    chk(sts_flags == m_flags, {req, " flags"}, sts_flags, m_flags);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(ff_valid == 1'b0, "R9 ff_valid", ff_valid, 0);
    chk(sts_flags == 4'h0, "R9 flags", sts_flags, 0);

    // R1 clean char into free stage
    stepc(1, 8'hA5, 0, 0, 0, 0, 0, 4'h0);
    chk(ff_valid && ff_data == 8'hA5 && !ff_fer && !ff_per, "R1 transfer", ff_data, 8'hA5);
    chk(sts_flags == 4'h0, "R1 flags", sts_flags, 0);

    // R5 overrun with framing error
    stepc(1, 8'h3C, 1, 0, 0, 0, 0, 4'h0);
    chk(ff_data == 8'hA5 && ff_valid, "R5 held byte", ff_data, 8'hA5);
    chk(sts_flags == 4'b1110, "R5 flags", sts_flags, 4'b1110);

    // R7 write 0 without read: no effect
    stepc(0, 0, 0, 0, 0, 0, 1, 4'h0);
    chk(sts_flags == 4'b1110, "R7 unarmed write", sts_flags, 4'b1110);
    // R7 read then clear overrun only
    stepc(0, 0, 0, 0, 0, 1, 0, 4'h0);
    stepc(0, 0, 0, 0, 0, 0, 1, 4'b1011);
    chk(sts_flags == 4'b1010, "R7 selective clear", sts_flags, 4'b1010);

    // R8 + R6 + R2: arm, then clear while a framing char lands as the stage drains
    stepc(0, 0, 0, 0, 0, 1, 0, 4'h0);
    stepc(1, 8'h5A, 1, 0, 1, 0, 1, 4'h0);
    chk(sts_flags == 4'b0010, "R8 set beats clear", sts_flags, 4'b0010);
    chk(ff_valid && ff_data == 8'h5A, "R6 drain-cycle accept", ff_data, 8'h5A);
    chk(ff_fer && !ff_per, "R2 framing tag", {ff_fer, ff_per}, 2'b10);

    // R3 parity only
    stepc(0, 0, 0, 0, 1, 1, 0, 4'h0);
    stepc(0, 0, 0, 0, 1, 0, 1, 4'h0);
    chk(sts_flags == 4'h0, "R7 full clear", sts_flags, 0);
    stepc(1, 8'h81, 0, 1, 1, 0, 0, 4'h0);
    chk(ff_valid && ff_per && !ff_fer && ff_data == 8'h81, "R3 parity tag", ff_data, 8'h81);
    chk(sts_flags == 4'b0001, "R3 flags", sts_flags, 4'b0001);

    // R4 both errors, no overrun
    stepc(1, 8'h7E, 1, 1, 1, 0, 0, 4'h0);
    chk(ff_fer && ff_per && ff_data == 8'h7E, "R4 both tags", ff_data, 8'h7E);
    chk(sts_flags == 4'b0011, "R4 flags", sts_flags, 4'b0011);

    // R6 stall holds
    for (int k = 0; k < 4; k++) begin
      stepc(0, 0, 0, 0, 0, 0, 0, 4'h0);
      chk(ff_valid && ff_data == 8'h7E, "R6 stall hold", ff_data, 8'h7E);
    end

    // random run against model
    for (int n = 0; n < 3000; n++) begin
      bit iv, fe, pe, rdy, rd, wr;
      bit [W-1:0] d;
      bit [3:0] wd;
      string req;
      iv  = ($urandom % 3) != 0;
      fe  = ($urandom % 4) == 0;
      pe  = ($urandom % 4) == 0;
      rdy = ($urandom % 2) == 0;
      rd  = ($urandom % 5) == 0;
      wr  = ($urandom % 5) == 0;
      d   = W'($urandom);
      wd  = 4'($urandom);
      if (iv && m_valid && !rdy) req = "R5";
      else if (wr)               req = "R7";
      else if (iv && fe && pe)   req = "R4";
      else if (iv && fe)         req = "R2";
      else if (iv && pe)         req = "R3";
      else if (iv)               req = "R1";
      else                       req = "R6";
      stepc(iv, d, fe, pe, rdy, rd, wr, wd);
      compare(req);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule